// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that lets a host read and write a bank of 8-bit configuration registers over a chip-select / serial-clock / data link. Every communication cycle opens with an instruction byte that selects the direction, the number of data bytes (one to four) and the first register address. The data phase then moves those bytes one after another, stepping the register address after each byte.

The serial pins are oversampled in the system clock domain. The link can run with one shared data pin, with this block driving it only while it returns read data. It can also run with separate input and output pins. Bit order and pin mode are taken from register 0 at the start of each instruction. Raising chip select abandons whatever was in progress and no partial byte is ever written. The whole register bank is also exposed as a flat parallel bus for the logic it configures.

Top module: `spi_cfg_port`

## Requirements
- R1: The first eight SCLK rising edges after chip select falls, or after the last data byte of a previous cycle, form the instruction byte. Bit 7 = 1 selects a read, bits 6:5 give the byte count minus one, and bits 4:0 give the start address. Only the addressed registers change.
- R2: A write moves 1 to 4 bytes. The address steps +1 after each byte in LSB-first order and -1 in MSB-first order, and it wraps modulo 32.
- R3: A read returns the current register contents. Each bit is driven after an SCLK falling edge and is held stable across the following rising edge, in the selected bit order.
- R4: A register takes its new value when the last bit of its byte is sampled. The value is visible on `regs_q` before the next SCLK falling edge.
- R5: Chip select high returns the port to the instruction phase. A byte that has not fully shifted in is never written.
- R6: Register 0 bit 0 selects the bit order: 1 = LSB first, 0 = MSB first. The order applies to both the instruction and the data bytes.
- R7: Register 0 bit 1 selects the pin mode: 1 = separate pins, 0 = shared pin. In shared mode `sdio_oe` is high only in the data phase of a read, and `sdo` stays 0. In separate mode read data appears on `sdo` and `sdio_oe` stays 0.
- R8: A change to bit order or pin mode takes effect only at the next instruction phase. Bytes still to come in the current cycle keep the old setting.
- R9: After the last data byte, the next eight rising edges are a new instruction, with no chip-select toggle needed.
- R10: After reset all registers are 0, which means MSB first and shared pin, and `sdio_oe` and `sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in (shared pin input or dedicated input) |
| sdio_o | output | 1 | Read data for the shared pin in shared mode |
| sdio_oe | output | 1 | Output enable for the shared pin |
| sdo | output | 1 | Read data on the dedicated output pin in separate mode |
| regs_q | output | NREG*8 | All registers, register n at bits 8n+7:8n |

## Verification
The assertions assume that each SCLK half period lasts several system clocks. They also assume that chip select rises no sooner than half an SCLK period after the last rising edge, so that a completed byte is never cut short by its own deselect. The bench holds every SCLK phase for six clocks and waits a full half period before and after toggling chip select. Random transactions write register 0 freely. Bit order and pin mode therefore wander through all four settings, and the bench model follows them, latching the mode at each instruction as the requirements prescribe.

// File: rtl/spi_cfg_pkg.sv
// Shared types for the serial configuration port.
// Assumes a 5-bit register address carried in the instruction byte.
package spi_cfg_pkg;

    localparam int ADDR_W      = 5;
    localparam int CTRL_LSB    = 0;   // register 0 bit: LSB-first order
    localparam int CTRL_4WIRE  = 1;   // register 0 bit: separate pins

    typedef enum logic [0:0] {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef struct packed {
        logic four_wire;
        logic lsb_first;
    } port_mode_t;

    typedef struct packed {
        logic              is_read;
        logic [1:0]        cnt_m1;
        logic [ADDR_W-1:0] addr;
    } instr_t;

endpackage

// File: rtl/spi_pin_front.sv
// Synchronises the serial pins into the system clock domain and
// produces single-cycle SCLK edge strobes.
// Assumes each SCLK level lasts at least SYNC_STAGES+2 system clocks.
module spi_pin_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_idle,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_s
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] RST_VAL = 3'b100;   // cs_n idles high

    logic [NPIN-1:0] pin_raw;
    logic [NPIN-1:0] chain [SYNC_STAGES];
    logic            sclk_d;

    assign pin_raw = {cs_n, sclk, sdi};

    genvar st;
    generate
        for (st = 0; st < SYNC_STAGES; st++) begin : g_stage
            // One flop rank of the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[st] <= RST_VAL;
                else if (st == 0)
                    chain[st] <= pin_raw;
                else
                    chain[st] <= chain[st-1];
            end
        end
    endgenerate

    // Delayed copy of synchronised SCLK for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= chain[SYNC_STAGES-1][1];
    end

    assign cs_idle   = chain[SYNC_STAGES-1][2];
    assign sdi_s     = chain[SYNC_STAGES-1][0];
    assign sclk_rise =  chain[SYNC_STAGES-1][1] & ~sclk_d;
    assign sclk_fall = ~chain[SYNC_STAGES-1][1] &  sclk_d;

endmodule

// File: rtl/spi_xfer_engine.sv
// Two-phase transfer engine: shifts in the instruction, then moves
// one to four data bytes, stepping the address after each byte.
// Assumes edge strobes from spi_pin_front; the mode is latched only
// while idle at the start of an instruction.
module spi_xfer_engine
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_idle,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    input  port_mode_t        mode_cfg,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output port_mode_t        mode_q,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo
);
    phase_e            phase;
    logic [2:0]        bit_idx;
    logic [7:0]        shreg;
    logic [7:0]        shift_nxt;
    logic              rd_q;
    logic [1:0]        bytes_left;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_step;
    logic [2:0]        out_sel;
    logic              out_q;
    instr_t            instr;

    assign busy      = (phase != PH_INSTR) || (bit_idx != 3'd0);
    assign shift_nxt = mode_q.lsb_first ? {sdi_s, shreg[7:1]}
                                        : {shreg[6:0], sdi_s};
    assign instr     = instr_t'(shift_nxt);
    assign addr_step = mode_q.lsb_first ? addr_q + 1'b1 : addr_q - 1'b1;
    assign out_sel   = mode_q.lsb_first ? bit_idx : 3'd7 - bit_idx;
    assign rd_addr   = addr_q;

    // Latch bit order and pin mode only between cycles
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= '0;
        else if (!busy) mode_q <= mode_cfg;
    end

    // Phase, bit counter, shift register and address sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_INSTR;
            bit_idx    <= 3'd0;
            shreg      <= 8'h00;
            rd_q       <= 1'b0;
            bytes_left <= 2'd0;
            addr_q     <= '0;
        end else if (cs_idle) begin
            phase   <= PH_INSTR;
            bit_idx <= 3'd0;
        end else if (sclk_rise) begin
            shreg   <= shift_nxt;
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
                if (phase == PH_INSTR) begin
                    rd_q       <= instr.is_read;
                    bytes_left <= instr.cnt_m1;
                    addr_q     <= instr.addr;
                    phase      <= PH_DATA;
                end else begin
                    addr_q <= addr_step;
                    if (bytes_left == 2'd0) phase <= PH_INSTR;
                    else                    bytes_left <= bytes_left - 2'd1;
                end
            end
        end
    end

    // Registered write strobe on the last bit of a write byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= 8'h00;
        end else begin
            wr_en <= 1'b0;
            if (!cs_idle && sclk_rise && bit_idx == 3'd7 &&
                phase == PH_DATA && !rd_q) begin
                wr_en   <= 1'b1;
                wr_addr <= addr_q;
                wr_data <= shift_nxt;
            end
        end
    end

    // Read bit launched on each SCLK falling edge
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle)
            out_q <= 1'b0;
        else if (sclk_fall)
            out_q <= (phase == PH_DATA && rd_q) ? rd_data[out_sel] : 1'b0;
    end

    assign sdio_oe = (phase == PH_DATA) && rd_q && !mode_q.four_wire && !cs_idle;
    assign sdio_o  = mode_q.four_wire ? 1'b0 : out_q;
    assign sdo     = mode_q.four_wire ? out_q : 1'b0;

endmodule

// File: rtl/spi_reg_bank.sv
// Bank of 8-bit configuration registers with one write port, one
// read port and a flat parallel view. Register 0 holds the port mode.
// Assumes NREG does not exceed the instruction address space.
module spi_reg_bank
    import spi_cfg_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output port_mode_t        mode_cfg,
    output logic [NREG*8-1:0] regs_q
);
    logic [7:0] regs [NREG];

    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_reg
            // One configuration register
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[r] <= 8'h00;
                else if (wr_en && wr_addr == ADDR_W'(r))
                    regs[r] <= wr_data;
            end
            assign regs_q[r*8 +: 8] = regs[r];
        end
    endgenerate

    // Read multiplexer; unmapped addresses read as zero
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
    end

    assign mode_cfg.lsb_first = regs[0][CTRL_LSB];
    assign mode_cfg.four_wire = regs[0][CTRL_4WIRE];

endmodule

// File: rtl/spi_cfg_port.sv
// Top of the serial configuration register port: pin front end,
// transfer engine and register bank.
// Assumes the host keeps SCLK low while chip select changes.
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int NREG        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo,
    output logic [NREG*8-1:0] regs_q
);
    logic              cs_idle, sclk_rise, sclk_fall, sdi_s;
    logic              wr_en, busy;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [7:0]        wr_data, rd_data;
    port_mode_t        mode_cfg, mode_q;

    spi_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .cs_idle(cs_idle), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sdi_s(sdi_s)
    );

    spi_xfer_engine u_engine (
        .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s),
        .mode_cfg(mode_cfg), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .mode_q(mode_q),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo)
    );

    spi_reg_bank #(.NREG(NREG)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .mode_cfg(mode_cfg), .regs_q(regs_q)
    );

endmodule

// File: rtl/spi_cfg_port_chk.sv
// Property checker for spi_cfg_port, attached by bind.
// Assumes SCLK levels last several clocks and chip select rises at
// least half an SCLK period after the last rising edge.
module spi_cfg_port_chk #(
    parameter int NREG = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREG*8-1:0] regs_q,
    input logic              sdio_o,
    input logic              sdio_oe,
    input logic              sdo,
    input logic              wr_en,
    input logic              cs_idle,
    input logic              sclk_rise,
    input logic              busy,
    input logic [1:0]        mode_bits
);
    logic was_rst;

    // Remember that the previous edge saw reset
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Reset leaves registers and data outputs cleared
    always @(posedge clk) begin
        if (was_rst === 1'b1)
            AST_RESET_CLEAR: assert (regs_q == '0 && !sdio_oe && !sdo); // R10
    end

    AST_REG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_q) |-> $past(wr_en)); // R4

    AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |-> !wr_en); // R5

    AST_READ_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |-> $stable(sdio_o) && $stable(sdo)); // R3

    AST_SHARED_PIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> (!mode_bits[1] && !sdo)); // R7

    AST_MODE_HELD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_bits)); // R8

endmodule

bind spi_cfg_port spi_cfg_port_chk #(.NREG(NREG)) i_chk (
    .clk(clk), .rst_n(rst_n), .regs_q(regs_q), .sdio_o(sdio_o),
    .sdio_oe(sdio_oe), .sdo(sdo), .wr_en(wr_en), .cs_idle(cs_idle),
    .sclk_rise(sclk_rise), .busy(busy), .mode_bits(mode_q)
);

// File: tb/test_spi_cfg_port.sv
// Bench for spi_cfg_port: directed corner cases plus seeded random
// transactions checked against a register model kept in the bench.
module test_spi_cfg_port;
    localparam int NREG = 32;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdio_o, sdio_oe, sdo;
    logic [NREG*8-1:0] regs_q;

    logic [7:0] mdl [NREG];
    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    spi_cfg_port #(.NREG(NREG)) i_spi_cfg_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .regs_q(regs_q)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(input int a);
        return regs_q[a*8 +: 8];
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift nbits of b in the given order; collect what the port drives
    task automatic send_bits(input logic [7:0] b, input bit lsb, input bit four,
                             input int nbits, output logic [7:0] got);
        got = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            int idx = lsb ? i : 7 - i;
            sdi = b[idx];
            wait_clk(HALF);
            got[idx] = four ? sdo : sdio_o;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic check_all(input string req);
        bit ok = 1'b1;
        for (int a = 0; a < NREG; a++) if (reg_at(a) !== mdl[a]) ok = 1'b0;
        chk(ok, req, 0, 0);
    endtask

    // One instruction plus data phase; chip select handled by caller
    task automatic xfer(input bit rd, input int n, input logic [4:0] addr,
                        input logic [31:0] data);
        bit lsb  = mdl[0][0];
        bit four = mdl[0][1];
        logic [4:0] a = addr;
        logic [7:0] got;
        logic [7:0] instr = {rd, 2'(n - 1), addr};
        chk(sdio_oe == 1'b0, "R7 oe low in instruction", sdio_oe, 0);
        send_bits(instr, lsb, four, 8, got);
        chk(sdio_oe == (rd && !four), "R7 oe in data phase", sdio_oe, rd && !four);
        for (int k = 0; k < n; k++) begin
            logic [7:0] b = data[k*8 +: 8];
            send_bits(rd ? 8'h00 : b, lsb, four, 8, got);
            wait_clk(1);
            if (rd) begin
                chk(got == mdl[a], "R3 read data", got, mdl[a]);
            end else begin
                mdl[a] = b;
                chk(reg_at(a) == b, "R4 register updated at byte end", reg_at(a), b);
            end
            if (four) chk(sdio_o == 1'b0 && sdio_oe == 1'b0, "R7 shared pin idle", sdio_oe, 0);
            else      chk(sdo == 1'b0, "R7 sdo idle in shared mode", sdo, 0);
            a = lsb ? a + 5'd1 : a - 5'd1;
        end
    endtask

    task automatic cycle(input bit rd, input int n, input logic [4:0] addr,
                         input logic [31:0] data, input string req);
        cs_n = 1'b0;
        wait_clk(HALF);
        xfer(rd, n, addr, data);
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        check_all(req);
    endtask

    initial begin
        logic [7:0] junk;
        void'($urandom(32'd20240611));
        for (int a = 0; a < NREG; a++) mdl[a] = 8'h00;
        wait_clk(4);
        chk(regs_q == '0 && sdio_oe == 1'b0 && sdo == 1'b0, "R10 reset state", regs_q[31:0], 0);
        rst_n = 1'b1;
        wait_clk(4);

        // MSB-first shared pin: address walks down
        cycle(1'b0, 3, 5'd12, 32'h00_33_22_11, "R2 R6 MSB-first write");
        chk(reg_at(11) == 8'h22 && reg_at(10) == 8'h33, "R2 decrement", reg_at(11), 8'h22);
        cycle(1'b1, 3, 5'd12, 32'h0, "R3 MSB-first read");
        cycle(1'b0, 1, 5'd31, 32'h5A, "R1 single byte top address");

        // Switch to LSB first: address walks up and wraps
        cycle(1'b0, 1, 5'd0, 32'h01, "R6 select LSB-first");
        cycle(1'b0, 4, 5'd20, 32'hD4_C3_B2_A1, "R2 LSB-first write");
        chk(reg_at(23) == 8'hD4, "R2 increment", reg_at(23), 8'hD4);
        cycle(1'b1, 4, 5'd20, 32'h0, "R3 LSB-first read");
        cycle(1'b0, 2, 5'd31, 32'h00_01_E7_00 >> 8, "R2 wrap 31 to 0");
        chk(reg_at(31) == 8'hE7, "R2 wrap write", reg_at(31), 8'hE7);

        // Mode write in mid-cycle: next byte keeps LSB-first
        cycle(1'b0, 2, 5'd0, 32'h00_00_96_02, "R8 mode held to cycle end");
        chk(reg_at(1) == 8'h96, "R8 second byte old order", reg_at(1), 8'h96);
        // Now MSB-first with separate pins
        cycle(1'b1, 3, 5'd12, 32'h0, "R7 separate-pin read");

        // Back-to-back instructions without deselect
        cs_n = 1'b0;
        wait_clk(HALF);
        xfer(1'b0, 1, 5'd7, 32'h3C);
        xfer(1'b1, 2, 5'd12, 32'h0);
        xfer(1'b0, 1, 5'd8, 32'hC3);
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        check_all("R9 streamed instructions");
        chk(reg_at(8) == 8'hC3, "R9 third instruction", reg_at(8), 8'hC3);

        // Abort inside a data byte: nothing written
        cs_n = 1'b0;
        wait_clk(HALF);
        send_bits({1'b0, 2'd0, 5'd5}, 1'b0, 1'b1, 8, junk);
        send_bits(8'hA5, 1'b0, 1'b1, 5, junk);
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        chk(reg_at(5) == mdl[5], "R5 partial byte dropped", reg_at(5), mdl[5]);
        // Abort inside the instruction, then a clean cycle
        cs_n = 1'b0;
        wait_clk(HALF);
        send_bits(8'hFF, 1'b0, 1'b1, 3, junk);
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        cycle(1'b0, 1, 5'd9, 32'h6B, "R5 restart after abort");
        chk(reg_at(9) == 8'h6B, "R5 restart write", reg_at(9), 8'h6B);

        // Back to shared pin, MSB first
        cycle(1'b0, 1, 5'd0, 32'h00, "R7 return to shared pin");

        // Seeded random traffic; register 0 writes roam all modes
        for (int t = 0; t < 60; t++) begin
            bit rd = 1'($urandom % 2);
            int n  = 1 + int'($urandom % 4);
            logic [4:0] ad = 5'($urandom % NREG);
            cycle(rd, n, ad, $urandom, "R1 R2 R3 random cycle");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule